// File: doc/BRIEF.md
# I2C Block-Transfer Byte Buffer

This block is a byte-addressed data buffer that sits next to an I2C command engine. It lets one combined transaction carry more than the eight data bytes a single command word can hold. Software programs the payload length, minus one, into a length register, turns block mode on, and rewinds the window pointer. It then moves the payload eight bytes at a time through one 64-bit window. The first byte of the message sits in the most significant byte lane of each word.

On the bus side, the command engine opens a transfer with a start pulse that names the direction. For an outgoing transfer, the engine takes one byte per ready/valid handshake. For an incoming transfer, it hands over one byte per valid strobe. Bytes move in ascending order until the programmed count is reached, and then a done flag rises. When block mode is off, the bus side stalls completely, so the engine can use its short command-word path instead. For a write, software fills the buffer before it issues the command. For a read, software drains the buffer only after the command completes.

Top module: `i2c_blk_fifo`

## Requirements
- R1: After reset the stored length-minus-one is 0, block mode is off, `tx_valid` and `xfer_done` are low, and the window pointer is at word 0.
- R2: A `cfg_len_we` pulse stores `cfg_len_data` (length minus one), which appears on `blk_len_m1` after the next clock edge. A `cfg_mode_we` pulse stores `cfg_mode_data` on `blk_mode` in the same way.
- R3: A window write stores byte lane k (bits 63-8k down to 56-8k) at buffer byte 8*P+k, where P is the window word pointer. The window pointer then moves to the next word.
- R4: A `ptr_rst` pulse returns the window pointer to word 0 at the next edge.
- R5: `win_rdata` combinationally shows buffer bytes 8*P..8*P+7, with the lowest address in bits 63:56. A `win_re` pulse advances the pointer.
- R6: After `xfer_start` with `xfer_rd`=0 and block mode on, `tx_valid` is high and `tx_byte` shows buffer bytes 0, 1, 2 and so on, one per accepted handshake. After length bytes, `xfer_done` rises and `tx_valid` falls.
- R7: After `xfer_start` with `xfer_rd`=1 and block mode on, each `rx_valid` cycle stores `rx_byte` at the next ascending address. Once length bytes have been stored, `xfer_done` is high and further `rx_valid` bytes change nothing.
- R8: While block mode is off, `tx_valid` stays low, `rx_valid` bytes are not stored, and the transfer count does not move.
- R9: In a window write, byte lanes whose address is beyond length minus one are not stored, and so they never reach the bus stream.
- R10: A window access made while the pointer is already at the last word of the programmed length leaves the pointer in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_we | input | 1 | Load the length register |
| cfg_len_data | input | 10 | Length minus one |
| cfg_mode_we | input | 1 | Load the block-mode bit |
| cfg_mode_data | input | 1 | Block-mode value |
| ptr_rst | input | 1 | Rewind the window pointer to word 0 |
| win_we | input | 1 | Window write strobe |
| win_wdata | input | 64 | Window write word, first byte in the MSB lane |
| win_re | input | 1 | Window read strobe (advances the pointer) |
| win_rdata | output | 64 | Word at the window pointer |
| blk_len_m1 | output | 10 | Stored length minus one, for the engine |
| blk_mode | output | 1 | Block mode enabled |
| xfer_start | input | 1 | Begin a bus data phase |
| xfer_rd | input | 1 | Direction for `xfer_start`: 1 is receive |
| tx_valid | output | 1 | A byte is offered to the engine |
| tx_ready | input | 1 | The engine takes the byte offered |
| tx_byte | output | 8 | Byte offered to the engine |
| rx_valid | input | 1 | The engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| xfer_done | output | 1 | All length bytes have been transferred |

## Verification
All state changes are registered. A strobe driven between two edges takes effect at the next rising edge, and `win_rdata`, `tx_valid`, `tx_byte` and `xfer_done` are combinational views of that state. So every result is due one edge after its stimulus. The bench drives two ns after a rising edge and reads results either at the same offset after the following edge or at the falling edge. The scoreboard monitor samples `tx_valid`/`tx_ready` at the falling edge, which is the handshake the next rising edge will accept. Each popped expected byte therefore lines up with exactly one transfer.

// File: rtl/i2c_blk_fifo_pkg.sv
package i2c_blk_fifo_pkg;

  localparam int WORD_BYTES = 8;
  localparam int LANE_BITS  = 3;

  // Bit index of the top of byte lane k; lane 0 holds the earliest byte.
  function automatic int lane_msb(input int k);
    return 63 - 8 * k;
  endfunction

  // Word index that holds the final byte of a transfer of (len_m1 + 1) bytes.
  function automatic int final_word(input int len_m1);
    return len_m1 / WORD_BYTES;
  endfunction

  // Byte address of lane k of word p.
  function automatic int lane_addr(input int p, input int k);
    return p * WORD_BYTES + k;
  endfunction

endpackage

// File: rtl/i2c_blk_fifo_regs.sv
module i2c_blk_fifo_regs #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_we,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic             mode_we,
  input  logic             mode_wdata,
  output logic [LEN_W-1:0] len_m1,
  output logic             mode_on
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_m1  <= '0;
      mode_on <= 1'b0;
    end else begin
      if (len_we)  len_m1  <= len_wdata;
      if (mode_we) mode_on <= mode_wdata;
    end
  end

  // R2
  len_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_we |=> len_m1 == $past(len_wdata));

  // R2
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_we |=> mode_on == $past(mode_wdata));

endmodule

// File: rtl/i2c_blk_fifo_swptr.sv
module i2c_blk_fifo_swptr #(
  parameter int LEN_W  = 10,
  parameter int WPTR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_rst,
  input  logic              access,
  input  logic [LEN_W-1:0]  len_m1,
  output logic [WPTR_W-1:0] wptr
);
  import i2c_blk_fifo_pkg::*;

  logic [WPTR_W-1:0] last_word;
  logic              at_last;
  logic              step_ev;

  assign last_word = WPTR_W'(final_word(int'(len_m1)));
  assign at_last   = (wptr >= last_word);
  assign step_ev   = access && !at_last && !ptr_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wptr <= '0;
    else if (ptr_rst) wptr <= '0;
    else if (step_ev) wptr <= wptr + 1'b1;
  end

  // R4
  ptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> wptr == '0);

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !ptr_rst && at_last) |=> $stable(wptr));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> wptr == $past(wptr) + 1'b1);

endmodule

// File: rtl/i2c_blk_fifo_bus.sv
module i2c_blk_fifo_bus #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_rd,
  input  logic             mode_on,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             tx_ready,
  input  logic             rx_valid,
  output logic             tx_valid,
  output logic             rx_we,
  output logic [LEN_W-1:0] byte_idx,
  output logic             done
);

  logic [LEN_W:0] cnt;
  logic [LEN_W:0] total;
  logic           active;
  logic           dir_rd;
  logic           tx_fire;

  assign total    = {1'b0, len_m1} + 1'b1;
  assign done     = active && (cnt == total);
  assign tx_valid = active && mode_on && !dir_rd && !done;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_we    = active && mode_on && dir_rd && !done && rx_valid && !start;
  assign byte_idx = cnt[LEN_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dir_rd <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      dir_rd <= start_rd;
      cnt    <= '0;
    end else if (tx_fire || rx_we) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt == '0) && !done);

  // R7
  done_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(cnt));

  // R8
  mode_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_on && !start) |=> $stable(cnt));

endmodule

// File: rtl/i2c_blk_fifo_store.sv
module i2c_blk_fifo_store #(
  parameter int MAX_BYTES = 1024,
  parameter int LEN_W     = 10,
  parameter int WPTR_W    = 7
) (
  input  logic              clk,
  input  logic              sw_we,
  input  logic [WPTR_W-1:0] wptr,
  input  logic [63:0]       sw_wdata,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              rx_we,
  input  logic [LEN_W-1:0]  bus_idx,
  input  logic [7:0]        rx_byte,
  output logic [63:0]       sw_rdata,
  output logic [7:0]        tx_byte
);
  import i2c_blk_fifo_pkg::*;

  logic [7:0] mem [MAX_BYTES];

  always_ff @(posedge clk) begin
    if (sw_we) begin
      for (int k = 0; k < WORD_BYTES; k++) begin
        if (lane_addr(int'(wptr), k) <= int'(len_m1))
          mem[LEN_W'(lane_addr(int'(wptr), k))] <= sw_wdata[lane_msb(k) -: 8];
      end
    end else if (rx_we) begin
      mem[bus_idx] <= rx_byte;
    end
  end

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    localparam logic [LANE_BITS-1:0] LANE = LANE_BITS'(g);
    assign sw_rdata[lane_msb(g) -: 8] = mem[{wptr, LANE}];
  end

  assign tx_byte = mem[bus_idx];

endmodule

// File: rtl/i2c_blk_fifo.sv
module i2c_blk_fifo #(
  parameter int MAX_BYTES = 1024,
  localparam int LEN_W    = $clog2(MAX_BYTES),
  localparam int WPTR_W   = LEN_W - 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_len_we,
  input  logic [LEN_W-1:0] cfg_len_data,
  input  logic             cfg_mode_we,
  input  logic             cfg_mode_data,
  input  logic             ptr_rst,
  input  logic             win_we,
  input  logic [63:0]      win_wdata,
  input  logic             win_re,
  output logic [63:0]      win_rdata,
  output logic [LEN_W-1:0] blk_len_m1,
  output logic             blk_mode,
  input  logic             xfer_start,
  input  logic             xfer_rd,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_byte,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  output logic             xfer_done
);

  logic [WPTR_W-1:0] wptr;
  logic [LEN_W-1:0]  bus_idx;
  logic              rx_we;
  logic              win_access;

  assign win_access = win_we || win_re;

  i2c_blk_fifo_regs #(.LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .len_we(cfg_len_we), .len_wdata(cfg_len_data),
    .mode_we(cfg_mode_we), .mode_wdata(cfg_mode_data),
    .len_m1(blk_len_m1), .mode_on(blk_mode)
  );

  i2c_blk_fifo_swptr #(.LEN_W(LEN_W), .WPTR_W(WPTR_W)) u_swptr (
    .clk(clk), .rst_n(rst_n), .ptr_rst(ptr_rst), .access(win_access),
    .len_m1(blk_len_m1), .wptr(wptr)
  );

  i2c_blk_fifo_bus #(.LEN_W(LEN_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .start(xfer_start), .start_rd(xfer_rd),
    .mode_on(blk_mode), .len_m1(blk_len_m1), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .tx_valid(tx_valid), .rx_we(rx_we),
    .byte_idx(bus_idx), .done(xfer_done)
  );

  i2c_blk_fifo_store #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .WPTR_W(WPTR_W)) u_store (
    .clk(clk), .sw_we(win_we), .wptr(wptr), .sw_wdata(win_wdata),
    .len_m1(blk_len_m1), .rx_we(rx_we), .bus_idx(bus_idx), .rx_byte(rx_byte),
    .sw_rdata(win_rdata), .tx_byte(tx_byte)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !tx_valid && !xfer_done && !blk_mode);

  // R8
  mode_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_mode |-> !tx_valid);

endmodule

// File: tb/i2c_blk_fifo_bench.sv
module i2c_blk_fifo_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_len_we = 1'b0;
  logic [9:0]  cfg_len_data = '0;
  logic        cfg_mode_we = 1'b0;
  logic        cfg_mode_data = 1'b0;
  logic        ptr_rst = 1'b0;
  logic        win_we = 1'b0;
  logic [63:0] win_wdata = '0;
  logic        win_re = 1'b0;
  logic [63:0] win_rdata;
  logic [9:0]  blk_len_m1;
  logic        blk_mode;
  logic        xfer_start = 1'b0;
  logic        xfer_rd = 1'b0;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [7:0]  tx_byte;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        xfer_done;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q [$];
  logic [7:0] pay [1024];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  i2c_blk_fifo u_i2c_blk_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_len_we(cfg_len_we), .cfg_len_data(cfg_len_data),
    .cfg_mode_we(cfg_mode_we), .cfg_mode_data(cfg_mode_data), .ptr_rst(ptr_rst),
    .win_we(win_we), .win_wdata(win_wdata), .win_re(win_re), .win_rdata(win_rdata),
    .blk_len_m1(blk_len_m1), .blk_mode(blk_mode), .xfer_start(xfer_start),
    .xfer_rd(xfer_rd), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .xfer_done(xfer_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a handshake seen at the falling edge is taken at the next rising edge.
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R6 unexpected tx byte", 64'(tx_byte), 64'h0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(tx_byte == e, "R6 tx byte order", 64'(tx_byte), 64'(e));
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic set_len(input int m1);
    cfg_len_data = 10'(m1); cfg_len_we = 1'b1; step(); cfg_len_we = 1'b0;
  endtask

  task automatic set_mode(input bit m);
    cfg_mode_data = m; cfg_mode_we = 1'b1; step(); cfg_mode_we = 1'b0;
  endtask

  task automatic rewind();
    ptr_rst = 1'b1; step(); ptr_rst = 1'b0;
  endtask

  // Driver: rewinds, writes pay[0..n-1] as MSB-first words (filler 8'hEE past n).
  task automatic load(input int n);
    rewind();
    for (int w = 0; w < (n + 7) / 8; w++) begin
      logic [63:0] d;
      for (int k = 0; k < 8; k++)
        d[63 - 8*k -: 8] = (w*8 + k < n) ? pay[w*8 + k] : 8'hEE;
      win_wdata = d; win_we = 1'b1; step(); win_we = 1'b0;
    end
  endtask

  task automatic start_xfer(input bit rd);
    xfer_rd = rd; xfer_start = 1'b1; step(); xfer_start = 1'b0;
  endtask

  task automatic drain(input int limit);
    tx_ready = 1'b1;
    for (int i = 0; i < limit && !xfer_done; i++) step();
    tx_ready = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    rx_byte = b; rx_valid = 1'b1; step(); rx_valid = 1'b0;
  endtask

  task automatic read_word(input logic [63:0] exp, input logic [63:0] mask, input string tag);
    chk((win_rdata & mask) == (exp & mask), tag, win_rdata & mask, exp & mask);
    win_re = 1'b1; step(); win_re = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step();
    // R1 reset state
    chk(blk_len_m1 == 10'd0, "R1 length reset", 64'(blk_len_m1), 64'h0);
    chk(blk_mode == 1'b0, "R1 mode reset", 64'(blk_mode), 64'h0);
    chk(!tx_valid && !xfer_done, "R1 bus idle", {tx_valid, xfer_done}, 64'h0);

    set_mode(1'b1);
    chk(blk_mode == 1'b1, "R2 mode load", 64'(blk_mode), 64'h1);

    // Prefill 24 bytes with a known pattern.
    set_len(23);
    chk(blk_len_m1 == 10'd23, "R2 length load", 64'(blk_len_m1), 64'd23);
    for (int i = 0; i < 24; i++) pay[i] = 8'(8'h10 + i);
    load(24);

    // R3/R9: 20-byte payload; final word carries filler in its low 4 lanes.
    set_len(19);
    for (int i = 0; i < 20; i++) pay[i] = 8'(8'h30 + i);
    load(20);
    for (int i = 0; i < 20; i++) exp_q.push_back(pay[i]);
    start_xfer(1'b0);
    chk(tx_valid == 1'b1, "R6 tx offered after start", 64'(tx_valid), 64'h1);
    drain(100);
    chk(exp_q.size() == 0, "R6 all 20 bytes sent", 64'(exp_q.size()), 64'h0);
    chk(xfer_done && !tx_valid, "R6 done and quiet", {xfer_done, tx_valid}, 64'h2);

    // R9: filler lanes were not stored; old bytes 20..23 remain.
    set_len(23);
    for (int i = 0; i < 20; i++) exp_q.push_back(8'(8'h30 + i));
    for (int i = 20; i < 24; i++) exp_q.push_back(8'(8'h10 + i));
    start_xfer(1'b0);
    drain(100);
    chk(exp_q.size() == 0, "R9 filler lanes not stored", 64'(exp_q.size()), 64'h0);

    // R7: receive 12 bytes, then 2 surplus bytes that must be dropped.
    set_len(11);
    start_xfer(1'b1);
    for (int i = 0; i < 12; i++) feed(8'(8'hA0 + i));
    chk(xfer_done == 1'b1, "R7 done after 12 rx bytes", 64'(xfer_done), 64'h1);
    feed(8'h55); feed(8'h56);
    rewind();
    // R4/R5: word 0 after rewind, first received byte in MSB lane.
    read_word(64'hA0A1A2A3A4A5A6A7, '1, "R5 word0 readback");
    // R7: surplus bytes did not touch bytes 12..15 (still 3C..3F).
    read_word(64'hA8A9AAAB3C3D3E3F, '1, "R7 surplus rx ignored");
    // R10: pointer held at last word.
    read_word(64'hA8A9AAAB3C3D3E3F, '1, "R10 pointer clamp");

    // R8: mode off stalls both directions.
    set_mode(1'b0);
    start_xfer(1'b0);
    tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk(!tx_valid && !xfer_done, "R8 no tx while mode off", {tx_valid, xfer_done}, 64'h0);
      step();
    end
    tx_ready = 1'b0;
    start_xfer(1'b1);
    for (int i = 0; i < 4; i++) feed(8'h77);
    chk(xfer_done == 1'b0, "R8 rx count frozen", 64'(xfer_done), 64'h0);
    set_mode(1'b1);
    rewind();
    read_word(64'hA0A1A2A3A4A5A6A7, '1, "R8 rx bytes not stored");
    // R4: pointer rewind after advancing.
    rewind();
    read_word(64'hA0A1A2A3A4A5A6A7, '1, "R4 rewind to word 0");

    // R6 boundary: full 1024-byte payload.
    set_len(1023);
    for (int i = 0; i < 1024; i++) pay[i] = 8'(i) ^ 8'h5A;
    load(1024);
    for (int i = 0; i < 1024; i++) exp_q.push_back(pay[i]);
    start_xfer(1'b0);
    drain(2000);
    chk(exp_q.size() == 0, "R6 1024-byte stream", 64'(exp_q.size()), 64'h0);
    chk(xfer_done == 1'b1, "R6 done at 1024", 64'(xfer_done), 64'h1);
    // R10 at maximum length: extra read stays on word 127.
    rewind();
    for (int w = 0; w < 127; w++) begin
      win_re = 1'b1; step(); win_re = 1'b0;
    end
    begin
      logic [63:0] lw;
      for (int k = 0; k < 8; k++) lw[63 - 8*k -: 8] = pay[1016 + k];
      read_word(lw, '1, "R10 last word at max length");
      read_word(lw, '1, "R10 clamp at max length");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule